// File: doc/BRIEF.md
# Four-Bit Accumulating Datapath with Hex Display

This block is a small accumulating datapath. A four-bit register holds a running value. Each time an update is due, a two-bit operation code picks one of four arithmetic or logic functions. The function combines the register contents, used as the first operand, with an external four-bit second operand, and the result goes back into the same register. The register contents also drive a hexadecimal seven-segment decoder, so the running value can be shown on a single display digit.

Updates do not happen on every edge of the fast board clock. A divider counter on that clock raises a single-cycle enable once every `TICK_DIV` cycles, and the register loads only on those cycles. At the default of 50,000,000 cycles with a 50 MHz clock, this gives one update per second. There is no second clock domain.

An asynchronous reset clears both the register and the divider. The first update after reset therefore arrives exactly one full divider period after reset is released.

Top module: `accum_dp_top`

## Requirements
- R1: While `rst_n` is low, `acc_value` is 0 without waiting for a clock edge, and `seg_n` shows the digit 0.
- R2: When an update is due and `opcode` is 2'b00, `acc_value` keeps its current value.
- R3: When an update is due and `opcode` is 2'b01, `acc_value` becomes its old value plus one, modulo 16, so 4'hF becomes 4'h0.
- R4: When an update is due and `opcode` is 2'b10, `acc_value` becomes its old value plus `operand_b`, modulo 16, and any carry is dropped.
- R5: When an update is due and `opcode` is 2'b11, `acc_value` becomes the bitwise AND of its old value and `operand_b`.
- R6: Updates are due only on one rising clock edge in every `TICK_DIV` edges. On every other edge, `acc_value` keeps its value whatever `opcode` and `operand_b` are. Only the inputs present at the updating edge matter.
- R7: After `rst_n` rises, the first update happens on the `TICK_DIV`-th rising clock edge, and later updates follow every `TICK_DIV` edges.
- R8: `seg_n` is active-low, with bit 6 = segment a, bit 5 = b, bit 4 = c, bit 3 = d, bit 2 = e, bit 1 = f and bit 0 = g. It shows the hex digit of `acc_value`, with the lit segments (active-high, written in the order abcdefg) being:
  - 0 = 1111110, 1 = 0110000, 2 = 1101101, 3 = 1111001
  - 4 = 0110011, 5 = 1011011, 6 = 1011111, 7 = 1110000
  - 8 = 1111111, 9 = 1111011, A = 1110111, b = 0011111
  - C = 1001110, d = 0111101, E = 1001111, F = 1000111

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast board clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand_b | input | 4 | Second operand of the function unit |
| opcode | input | 2 | Selects hold, increment, add or AND |
| acc_value | output | 4 | Current register contents |
| seg_n | output | 7 | Active-low segment pattern, a at bit 6 down to g at bit 0 |

## Verification
The bench builds the block with `TICK_DIV` set to 4 and leaves the data width at 4.

With a divider of 4, the bench can reach every hex digit, the wrap from F to 0, and a carry-dropping addition in a few hundred cycles. The same short period lets it check that the value holds on the three edges before each update. It also lets it check that inputs changed just before the updating edge are the only ones that count, and that a reset in the middle of a period restarts the divider count.

// File: rtl/accum_pkg.sv
package accum_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_INC  = 2'b01,
        OP_ADD  = 2'b10,
        OP_AND  = 2'b11
    } acc_op_e;

endpackage

// File: rtl/accum_tick_gen.sv
module accum_tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);
endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  acc_op_e           op_i,
    output logic [DATA_W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_HOLD: y_o = a_i;
            OP_INC:  y_o = a_i + DATA_W'(1);
            OP_ADD:  y_o = a_i + b_i;
            OP_AND:  y_o = a_i & b_i;
            default: y_o = a_i;
        endcase
    end
endmodule

// File: rtl/accum_hex7.sv
module accum_hex7 (
    input  logic [3:0] nib_i,
    output logic [6:0] seg_n_o
);
    logic [6:0] lit;

    always_comb begin
        unique case (nib_i)
            4'h0: lit = 7'b1111110;
            4'h1: lit = 7'b0110000;
            4'h2: lit = 7'b1101101;
            4'h3: lit = 7'b1111001;
            4'h4: lit = 7'b0110011;
            4'h5: lit = 7'b1011011;
            4'h6: lit = 7'b1011111;
            4'h7: lit = 7'b1110000;
            4'h8: lit = 7'b1111111;
            4'h9: lit = 7'b1111011;
            4'hA: lit = 7'b1110111;
            4'hB: lit = 7'b0011111;
            4'hC: lit = 7'b1001110;
            4'hD: lit = 7'b0111101;
            4'hE: lit = 7'b1001111;
            default: lit = 7'b1000111;
        endcase
    end

    assign seg_n_o = ~lit;
endmodule

// File: rtl/accum_dp_top.sv
module accum_dp_top
    import accum_pkg::*;
#(
    parameter int DATA_W   = 4,
    parameter int TICK_DIV = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand_b,
    input  logic [1:0]        opcode,
    output logic [DATA_W-1:0] acc_value,
    output logic [6:0]        seg_n
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic              tick_w;
    logic [DATA_W-1:0] alu_y;

    accum_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    accum_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i  (st_q.acc),
        .b_i  (operand_b),
        .op_i (acc_op_e'(opcode)),
        .y_o  (alu_y)
    );

    always_comb begin
        st_d = st_q;
        if (tick_w) begin
            st_d.acc = alu_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_value = st_q.acc;

    accum_hex7 u_hex (
        .nib_i   (st_q.acc[3:0]),
        .seg_n_o (seg_n)
    );
endmodule

// File: rtl/accum_dp_chk.sv
module accum_dp_chk #(
    parameter int DATA_W   = 4,
    parameter int TICK_DIV = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [1:0]        opcode,
    input logic [DATA_W-1:0] operand_b,
    input logic [DATA_W-1:0] acc_value
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> acc_value == '0); // R1

    AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && opcode == 2'b00) |=> $stable(acc_value)); // R2

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && opcode == 2'b01) |=> acc_value == DATA_W'($past(acc_value) + 1'b1)); // R3

    AST_ADD_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && opcode == 2'b10) |=> acc_value == DATA_W'($past(acc_value) + $past(operand_b))); // R4

    AST_AND_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && opcode == 2'b11) |=> acc_value == ($past(acc_value) & $past(operand_b))); // R5

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(acc_value)); // R6

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> gap_q == LAST); // R7

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= LAST); // R7
endmodule

bind accum_dp_top accum_dp_chk #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .opcode    (opcode),
    .operand_b (operand_b),
    .acc_value (acc_value)
);

// File: tb/accum_dp_top_tb.sv
module accum_dp_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] operand_b = '0;
    logic [1:0] opcode = '0;
    logic [3:0] acc_value;
    logic [6:0] seg_n;

    int checks = 0;
    int failures = 0;
    logic [3:0] model = '0;

    accum_dp_top #(.DATA_W(4), .TICK_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_b (operand_b),
        .opcode    (opcode),
        .acc_value (acc_value),
        .seg_n     (seg_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] seg_expect(input logic [3:0] v);
        logic [6:0] on;
        case (v)
            4'h0: on = 7'b1111110;  4'h1: on = 7'b0110000;
            4'h2: on = 7'b1101101;  4'h3: on = 7'b1111001;
            4'h4: on = 7'b0110011;  4'h5: on = 7'b1011011;
            4'h6: on = 7'b1011111;  4'h7: on = 7'b1110000;
            4'h8: on = 7'b1111111;  4'h9: on = 7'b1111011;
            4'hA: on = 7'b1110111;  4'hB: on = 7'b0011111;
            4'hC: on = 7'b1001110;  4'hD: on = 7'b0111101;
            4'hE: on = 7'b1001111;  default: on = 7'b1000111;
        endcase
        return ~on;
    endfunction

    task automatic check_val(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_next(input logic [1:0] op, input logic [3:0] b);
        case (op)
            2'b00: return model;
            2'b01: return model + 4'd1;
            2'b10: return model + b;
            default: return model & b;
        endcase
    endfunction

    // Called at a negedge aligned to the divider; consumes exactly DIV rising edges.
    task automatic step(input logic [1:0] op, input logic [3:0] b, input string req);
        opcode = op;
        operand_b = b;
        repeat (DIV-1) @(posedge clk);
        @(negedge clk);
        check_val("R6 hold between ticks", {3'b0, acc_value}, {3'b0, model});
        @(posedge clk);
        @(negedge clk);
        model = model_next(op, b);
        check_val(req, {3'b0, acc_value}, {3'b0, model});
        check_val("R8 segments", seg_n, seg_expect(model));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        model = '0;
        check_val("R1 reset value", {3'b0, acc_value}, 7'd0);
        check_val("R1 reset segments", seg_n, seg_expect(4'h0));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_hold();
        step(2'b11, 4'h0, "R5 clear via AND");
        step(2'b10, 4'h9, "R4 load 9");
        step(2'b00, 4'hF, "R2 hold with B=F");
        step(2'b00, 4'h3, "R2 hold again");
    endtask

    task automatic t_inc_wrap();
        step(2'b10, 4'h5, "R4 add 5 to 9");
        step(2'b01, 4'h0, "R3 increment E");
        step(2'b01, 4'h7, "R3 wrap F to 0");
    endtask

    task automatic t_add_carry();
        step(2'b10, 4'hC, "R4 add C to 0");
        step(2'b10, 4'h7, "R4 carry dropped");
        step(2'b10, 4'h0, "R4 add zero");
    endtask

    task automatic t_and();
        step(2'b10, 4'hA, "R4 set up");
        step(2'b11, 4'hF, "R5 AND with F");
        step(2'b11, 4'h6, "R5 AND with 6");
    endtask

    task automatic t_late_change();
        opcode = 2'b10;
        operand_b = 4'h7;
        repeat (DIV-1) @(posedge clk);
        @(negedge clk);
        check_val("R6 no early update", {3'b0, acc_value}, {3'b0, model});
        opcode = 2'b01;
        operand_b = 4'h0;
        @(posedge clk);
        @(negedge clk);
        model = model + 4'd1;
        check_val("R6 only edge inputs used", {3'b0, acc_value}, {3'b0, model});
    endtask

    task automatic t_mid_reset();
        step(2'b10, 4'h5, "R4 before reset");
        opcode = 2'b01;
        repeat (2) @(posedge clk);
        t_reset();
        step(2'b01, 4'h0, "R7 first update after reset");
        step(2'b01, 4'h0, "R7 second update");
    endtask

    task automatic t_all_digits();
        step(2'b11, 4'h0, "R5 clear");
        for (int i = 0; i < 16; i++) begin
            step(2'b01, 4'h0, "R8 digit sweep");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_hold();
        t_inc_wrap();
        t_add_carry();
        t_and();
        t_late_change();
        t_mid_reset();
        t_all_digits();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule